// File: doc/BRIEF.md
# UART Data Register Front End

This block is the byte-wide data side of a 16550-style UART as seen from a simple register bus. One bus address carries three meanings: a read pops the oldest received character, a write queues a character for transmission, and while the divisor access bit in the line control byte is set the same address instead reaches the low byte of the 16-bit baud divisor. Receive and transmit each have either a single holding register or a FIFO, chosen by a FIFO enable bit. The block keeps the data-ready, transmit-empty and overrun flags.

The serial shifters are not part of it. A strobe with a byte stands for a character that has come off the line. A second strobe says that the transmit shifter has taken the character offered on the transmit output. The block also produces the 16x oversampling tick from the divisor. Transfers in both directions are held off while the divisor is zero and for a settle time after every divisor write.

Top module: `uart_data_front`

## Requirements
- R1: After reset the status byte reads 0x20, both divisor bytes read 0, the FIFOs are disabled, and `baud_tick`, `xfer_ok` and `tx_avail` are low.
- R2: The access bit is bit 7 of the line control byte at address 3. While it is 1, address 0 reads and writes the divisor low byte and address 1 reads and writes the high byte, and transmit data is left untouched. While it is 0, address 0 reads receive data and writes transmit data.
- R3: For a nonzero divisor D, `baud_tick` is high for one cycle every D cycles. Any divisor byte write restarts the count, so the first tick falls in the D-th cycle after the write.
- R4: While the divisor is 0 there is no tick, `xfer_ok` is low, arriving characters are ignored and `tx_avail` stays low.
- R5: After any divisor byte write, `xfer_ok` stays low for SETTLE cycles (default 8). It then rises if the divisor is nonzero.
- R6: With FIFOs disabled, a character that arrives while the previous one is unread replaces it and sets overrun (status bit 1).
- R7: Data-ready (status bit 0) clears when the last held receive character is read. A data read while data-ready is 0 returns 0x00.
- R8: With FIFOs enabled, reads return received characters oldest first. A character arriving while the receive FIFO is full is dropped, the stored characters are kept, and overrun is set.
- R9: Overrun stays set until the status byte at address 5 is read. That read clears it.
- R10: With FIFOs disabled, a transmit write clears transmit-empty (status bit 5). A second write before the take replaces the held character. The take sets transmit-empty again.
- R11: With FIFOs enabled, up to TX_DEPTH characters are offered in write order. Writes to a full FIFO are lost. Transmit-empty sets when the last character is taken.
- R12: Writing the FIFO control byte at address 2 with a bit 0 that differs from the current mode switches the mode and empties both directions: data-ready 0, transmit-empty 1, `tx_avail` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Strobe: a character has arrived |
| rx_char | input | 8 | Arriving character |
| tx_take | input | 1 | Strobe: shifter takes the offered character |
| tx_char | output | 8 | Character offered to the shifter |
| tx_avail | output | 1 | A character is offered |
| baud_tick | output | 1 | 16x oversampling tick |
| xfer_ok | output | 1 | Divisor nonzero and settled |

## Verification
The bench builds the block with both FIFO depths set to 4 and SETTLE left at 8. The small depth lets random mixes of arrivals, reads, writes and takes reach the full-FIFO drop and overrun cases within a few operations. It also places the depth-plus-one write loss next to a short drain in one directed test. The default settle length puts the hold-off window and the first ticks of a divisor of 5 within one 20-cycle trace.

// File: rtl/uart_dp_pkg.sv
package uart_dp_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    ADR_DATA  = 3'd0,
    ADR_DIVHI = 3'd1,
    ADR_FCTL  = 3'd2,
    ADR_LCTL  = 3'd3,
    ADR_LSTAT = 3'd5
  } reg_addr_e;

  localparam int LCR_ACCESS_BIT = 7;
  localparam int FCR_EN_BIT     = 0;
  localparam int LSR_READY_BIT  = 0;
  localparam int LSR_OVR_BIT    = 1;
  localparam int LSR_EMPTY_BIT  = 5;
endpackage

// File: rtl/uart_dp_baud.sv
module uart_dp_baud #(
  parameter int SETTLE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_lo,
  input  logic       we_hi,
  input  logic [7:0] wdata,
  output logic [15:0] divisor,
  output logic       tick,
  output logic       ready
);
  localparam int SW = $clog2(SETTLE + 1);

  logic [15:0]   div_q, div_d;
  logic [15:0]   cnt_q, cnt_d;
  logic [SW-1:0] hold_q, hold_d;
  logic          div_we;

  assign div_we  = we_lo | we_hi;
  assign tick    = (div_q != 16'd0) && (cnt_q == div_q - 16'd1);
  assign ready   = (div_q != 16'd0) && (hold_q == '0);
  assign divisor = div_q;

  always_comb begin
    div_d = div_q;
    if (we_lo) div_d[7:0]  = wdata;
    if (we_hi) div_d[15:8] = wdata;

    hold_d = hold_q;
    if (div_we)              hold_d = SW'(SETTLE);
    else if (hold_q != '0)   hold_d = hold_q - 1'b1;

    if (div_we || div_q == 16'd0 || tick) cnt_d = '0;
    else                                  cnt_d = cnt_q + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  // R5: a divisor write always opens the hold-off window
  p_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> !ready);
  // R3: ticks are single-cycle pulses for divisors above 1
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q > 16'd1 && !div_we) |=> !tick);
endmodule

// File: rtl/uart_dp_fifo.sv
module uart_dp_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign rdata   = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  // R8: an accepted push leaves the queue non-empty
  p_fifo_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr && !full) |=> !empty);
  // R11: a push into a full queue never lowers the fill
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> full);
endmodule

// File: rtl/uart_data_front.sv
module uart_data_front
  import uart_dp_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16,
  parameter int SETTLE   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_char,
  input  logic        tx_take,
  output logic [7:0]  tx_char,
  output logic        tx_avail,
  output logic        baud_tick,
  output logic        xfer_ok
);
  logic       rs_meta, rs_n;
  logic [7:0] lcr_q, lcr_d;
  logic       fen_q, fen_d;
  logic [7:0] rxh_q, rxh_d, txh_q, txh_d;
  logic       rxh_full_q, rxh_full_d, txh_full_q, txh_full_d;
  logic       oe_q, oe_d;
  logic       wr, rd, access, data_wr, data_rd, lsr_rd, fcr_flip;
  logic       rx_acc, tx_acc, dr, thre, oe_set;
  logic [7:0] rxf_head, txf_head;
  logic       rxf_empty, rxf_full, txf_empty, txf_full;
  logic [15:0] divisor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  assign access   = lcr_q[LCR_ACCESS_BIT];
  assign wr       = bus_sel && bus_wr;
  assign rd       = bus_sel && !bus_wr;
  assign data_wr  = wr && bus_addr == ADR_DATA && !access;
  assign data_rd  = rd && bus_addr == ADR_DATA && !access;
  assign lsr_rd   = rd && bus_addr == ADR_LSTAT;
  assign fcr_flip = wr && bus_addr == ADR_FCTL && (bus_wdata[FCR_EN_BIT] != fen_q);
  assign rx_acc   = rx_valid && xfer_ok;
  assign tx_acc   = tx_take && tx_avail;

  uart_dp_baud #(.SETTLE(SETTLE)) u_baud (
    .clk(clk), .rst_n(rs_n),
    .we_lo(wr && bus_addr == ADR_DATA && access),
    .we_hi(wr && bus_addr == ADR_DIVHI && access),
    .wdata(bus_wdata), .divisor(divisor), .tick(baud_tick), .ready(xfer_ok)
  );

  uart_dp_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rs_n), .clr(fcr_flip),
    .push(rx_acc && fen_q), .wdata(rx_char),
    .pop(data_rd && fen_q), .rdata(rxf_head),
    .empty(rxf_empty), .full(rxf_full)
  );

  uart_dp_fifo #(.DEPTH(TX_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rs_n), .clr(fcr_flip),
    .push(data_wr && fen_q), .wdata(bus_wdata),
    .pop(tx_acc && fen_q), .rdata(txf_head),
    .empty(txf_empty), .full(txf_full)
  );

  assign dr       = fen_q ? !rxf_empty : rxh_full_q;
  assign thre     = fen_q ? txf_empty : !txh_full_q;
  assign tx_avail = xfer_ok && (fen_q ? !txf_empty : txh_full_q);
  assign tx_char  = fen_q ? txf_head : txh_q;
  assign oe_set   = !fcr_flip && rx_acc && (fen_q ? rxf_full : (rxh_full_q && !data_rd));

  always_comb begin
    lcr_d      = lcr_q;
    fen_d      = fen_q;
    rxh_d      = rxh_q;
    rxh_full_d = rxh_full_q;
    txh_d      = txh_q;
    txh_full_d = txh_full_q;
    if (wr && bus_addr == ADR_LCTL) lcr_d = bus_wdata;
    if (fcr_flip) begin
      fen_d      = bus_wdata[FCR_EN_BIT];
      rxh_full_d = 1'b0;
      txh_full_d = 1'b0;
    end else if (!fen_q) begin
      if (data_rd) rxh_full_d = 1'b0;
      if (rx_acc) begin
        rxh_d      = rx_char;
        rxh_full_d = 1'b1;
      end
      if (tx_acc) txh_full_d = 1'b0;
      if (data_wr) begin
        txh_d      = bus_wdata;
        txh_full_d = 1'b1;
      end
    end
    if (oe_set)      oe_d = 1'b1;
    else if (lsr_rd) oe_d = 1'b0;
    else             oe_d = oe_q;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      lcr_q      <= '0;
      fen_q      <= 1'b0;
      rxh_q      <= '0;
      rxh_full_q <= 1'b0;
      txh_q      <= '0;
      txh_full_q <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      lcr_q      <= lcr_d;
      fen_q      <= fen_d;
      rxh_q      <= rxh_d;
      rxh_full_q <= rxh_full_d;
      txh_q      <= txh_d;
      txh_full_q <= txh_full_d;
      oe_q       <= oe_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (bus_addr)
        ADR_DATA:  bus_rdata = access ? divisor[7:0] : (dr ? (fen_q ? rxf_head : rxh_q) : 8'h00);
        ADR_DIVHI: bus_rdata = access ? divisor[15:8] : 8'h00;
        ADR_LCTL:  bus_rdata = lcr_q;
        ADR_LSTAT: begin
          bus_rdata[LSR_READY_BIT] = dr;
          bus_rdata[LSR_OVR_BIT]   = oe_q;
          bus_rdata[LSR_EMPTY_BIT] = thre;
        end
        default:   bus_rdata = 8'h00;
      endcase
    end
  end

  // R6: an unread held character that is replaced raises overrun
  p_rx_overrun_r6: assert property (@(posedge clk) disable iff (!rs_n)
    (!fen_q && rx_acc && rxh_full_q && !data_rd && !fcr_flip) |=> oe_q);
  // R8: an arrival at a full receive queue raises overrun
  p_rx_drop_r8: assert property (@(posedge clk) disable iff (!rs_n)
    (fen_q && rx_valid && xfer_ok && rxf_full && !fcr_flip) |=> oe_q);
  // R9: overrun holds until the status read
  p_oe_sticky_r9: assert property (@(posedge clk) disable iff (!rs_n)
    (oe_q && !lsr_rd) |=> oe_q);
  // R10: a holding-register write clears transmit-empty
  p_thre_clr_r10: assert property (@(posedge clk) disable iff (!rs_n)
    (!fen_q && data_wr && !fcr_flip) |=> !thre);
  // R4: arrivals are ignored while transfers are held off
  p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rs_n)
    (!fen_q && !xfer_ok && !rxh_full_q && !fcr_flip) |=> !rxh_full_q);
  // R12: a mode change leaves both directions empty
  p_flip_clear_r12: assert property (@(posedge clk) disable iff (!rs_n)
    fcr_flip |=> (thre && !dr));
endmodule

// File: tb/uart_data_front_tb_top.sv
module uart_data_front_tb_top;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       rx_valid, tx_take, tx_avail, baud_tick, xfer_ok;
  logic [7:0] rx_char, tx_char;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  uart_data_front #(.RX_DEPTH(DEPTH), .TX_DEPTH(DEPTH), .SETTLE(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_char(rx_char), .tx_take(tx_take),
    .tx_char(tx_char), .tx_avail(tx_avail), .baud_tick(baud_tick), .xfer_ok(xfer_ok)
  );

  function automatic logic [7:0] lsr_exp(input logic thre, input logic oe, input logic dr);
    return {2'b00, thre, 3'b000, oe, dr};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rx_in(input logic [7:0] d);
    rx_valid = 1'b1; rx_char = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic take1();
    tx_take = 1'b1;
    @(negedge clk);
    tx_take = 1'b0;
  endtask

  byte unsigned rxm[DEPTH];
  byte unsigned txm[DEPTH];
  int rxn = 0, txn = 0;
  bit moe = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_char = 0; tx_take = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    brd(3'd5, d); chk("R1 status", d, 8'h20);
    chk("R1 tick", baud_tick, 0); chk("R1 xfer_ok", xfer_ok, 0); chk("R1 tx_avail", tx_avail, 0);
    bwr(3'd3, 8'h80);
    brd(3'd0, d); chk("R1 div lo", d, 8'h00);
    brd(3'd1, d); chk("R1 div hi", d, 8'h00);
    bwr(3'd3, 8'h03);

    // R4 zero divisor gates traffic
    rx_in(8'h77);
    brd(3'd5, d); chk("R4 rx ignored status", d, 8'h20);
    bwr(3'd0, 8'hA5);
    for (int i = 0; i < 30; i++) begin
      chk("R4 no tick", baud_tick, 0);
      chk("R4 tx held", tx_avail, 0);
      @(negedge clk);
    end

    // R2/R3/R5 divisor of 5
    bwr(3'd3, 8'h80);
    bwr(3'd0, 8'h05);
    for (int i = 1; i <= 20; i++) begin
      chk("R3 tick phase", baud_tick, (i % 5) == 0);
      chk("R5 settle", xfer_ok, i >= 9);
      @(negedge clk);
    end
    brd(3'd0, d); chk("R2 div lo readback", d, 8'h05);
    brd(3'd1, d); chk("R2 div hi readback", d, 8'h00);
    bwr(3'd3, 8'h03);
    chk("R2 tx kept through divisor access", tx_char, 8'hA5);
    chk("R10 tx offered", tx_avail, 1);

    // R10 overwrite then take
    bwr(3'd0, 8'h3C);
    chk("R10 overwrite", tx_char, 8'h3C);
    brd(3'd5, d); chk("R10 thre clear", d, 8'h00);
    take1();
    chk("R10 avail after take", tx_avail, 0);
    brd(3'd5, d); chk("R10 thre set", d, 8'h20);

    // R6/R7/R9 single holding register
    rx_in(8'h11);
    brd(3'd5, d); chk("R7 data ready", d, 8'h21);
    rx_in(8'h22);
    brd(3'd5, d); chk("R6 overrun", d, 8'h23);
    brd(3'd5, d); chk("R9 overrun cleared by read", d, 8'h21);
    brd(3'd0, d); chk("R6 newest kept", d, 8'h22);
    brd(3'd5, d); chk("R7 ready cleared", d, 8'h20);
    brd(3'd0, d); chk("R7 empty read", d, 8'h00);

    // R12 into FIFO mode
    bwr(3'd2, 8'h01);
    brd(3'd5, d); chk("R12 fifo on status", d, 8'h20);

    // R11 directed: depth+1 writes
    for (int i = 0; i <= DEPTH; i++) bwr(3'd0, 8'h40 + 8'(i));
    brd(3'd5, d); chk("R11 thre clear", d, 8'h00);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R11 order", tx_char, 8'h40 + 8'(i));
      chk("R11 avail", tx_avail, 1);
      take1();
    end
    chk("R11 fifth lost", tx_avail, 0);
    brd(3'd5, d); chk("R11 thre set", d, 8'h20);

    // R8 directed: depth+1 arrivals
    for (int i = 0; i <= DEPTH; i++) rx_in(8'h60 + 8'(i));
    brd(3'd5, d); chk("R8 overrun on full", d, 8'h23);
    for (int i = 0; i < DEPTH; i++) begin
      brd(3'd0, d); chk("R8 order kept", d, 8'h60 + 8'(i));
    end
    brd(3'd5, d); chk("R7 fifo drained", d, 8'h20);

    // random mix in FIFO mode
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [7:0] b;
      op = int'($urandom_range(0, 3));
      b  = 8'($urandom);
      case (op)
        0: begin
          rx_in(b);
          if (rxn < DEPTH) begin rxm[rxn] = b; rxn++; end
          else moe = 1'b1;
        end
        1: begin
          brd(3'd0, d);
          if (rxn > 0) begin
            chk("R8 random head", d, rxm[0]);
            for (int k = 0; k < DEPTH - 1; k++) rxm[k] = rxm[k+1];
            rxn--;
          end else chk("R7 random empty", d, 8'h00);
        end
        2: begin
          bwr(3'd0, b);
          if (txn < DEPTH) begin txm[txn] = b; txn++; end
        end
        default: begin
          chk("R11 random avail", tx_avail, txn > 0);
          if (txn > 0) begin
            chk("R11 random head", tx_char, txm[0]);
            for (int k = 0; k < DEPTH - 1; k++) txm[k] = txm[k+1];
            txn--;
          end
          take1();
        end
      endcase
      brd(3'd5, d);
      chk("R9 random status", d, lsr_exp(txn == 0, moe, rxn > 0));
      moe = 1'b0;
    end

    // R12 leave FIFO mode with data held
    rx_in(8'h01); rx_in(8'h02); bwr(3'd0, 8'h55);
    brd(3'd5, d);
    bwr(3'd2, 8'h00);
    brd(3'd5, d); chk("R12 cleared status", d, 8'h20);
    chk("R12 nothing offered", tx_avail, 0);

    // R3 rewrite divisor to 2, then R4 back to 0
    bwr(3'd3, 8'h80);
    bwr(3'd0, 8'h02);
    bwr(3'd1, 8'h00);
    for (int i = 1; i <= 12; i++) begin
      chk("R3 divisor 2 phase", baud_tick, (i % 2) == 0);
      @(negedge clk);
    end
    bwr(3'd0, 8'h00);
    for (int i = 1; i <= 20; i++) begin
      chk("R4 zero divisor tick", baud_tick, 0);
      chk("R4 zero divisor xfer", xfer_ok, 0);
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule